// File: doc/BRIEF.md
# Vectored Interrupt Priority Encoder

This block gathers a set of internal interrupt sources and hands a processor one byte-wide vector naming the most urgent source that is both pending and enabled. Each source raises its request with a single-cycle event pulse, which the block catches in a pending latch. An enable bit for each source decides whether that latch can reach the processor. Priority is fixed by source index. Source 0 has the highest vector code, and every following source has a code two below the one before it. Every code is therefore even, and vector 00h means that nothing is waiting.

The vector register does not move while the processor works on it, even when a more urgent source arrives in the meantime. A write strobe to the register acknowledges the source the vector names. That clears its pending latch, and on the same edge the register loads the next enabled pending source, or 00h if there is none. While the register reads 00h it picks up the next request by itself. A separate registered request line is the OR of all enabled pending sources.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, `vec_q` reads 00h and `irq` is 0, and no source is pending.
- R2: Source i has vector code TOP_CODE - 2*i (defaults: 0x88 for source 0, 0x12 for source 59 of 60), so bit 0 of a nonzero vector is always 0.
- R3: When no source is both pending and enabled, `vec_q` reads 00h once the current vector has been acknowledged.
- R4: When several enabled sources are pending together, the vector loaded is the one with the lowest source index, which has the highest code.
- R5: A high cycle on `ack_wr` while `vec_q` is nonzero clears the named source's pending latch, and on the same edge loads the next enabled pending source (or 00h). A strobe while `vec_q` is 00h changes nothing.
- R6: A nonzero vector holds its value until `ack_wr` is asserted, even if a higher-priority source becomes pending.
- R7: While `vec_q` is 00h, an event sampled at clock edge k appears in `vec_q` after edge k+1.
- R8: `irq` is a registered OR of all enabled pending latches. It rises one edge after a latch sets, and it falls one edge after the last enabled latch clears.
- R9: An event on a source in the same cycle as the acknowledge of that source leaves it pending, so its vector is presented again.
- R10: A pending source whose enable is 0 stays latched but is invisible to `vec_q` and `irq`. Once it is enabled, it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | NUM_SRC | One-cycle event pulse for each source |
| src_en | input | NUM_SRC | Enable for each source |
| ack_wr | input | 1 | Write strobe to the vector register; acknowledges the current vector |
| vec_q | output | 8 | Current vector; 00h when none |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is an event on a source in exactly the cycle its own vector is acknowledged. The stimulus raises the event pulse and the write strobe on the same falling edge. It then watches `vec_q` drop to 00h for one cycle and come back to the same code. Holding the vector against a more urgent arrival is reached by pulsing a low-priority source, waiting for its vector, and only then pulsing source 1. The bench checks that the old code survives several cycles and gives way only at the acknowledge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  // Vector code for a source index: fixed, even, decreasing with index.
  function automatic logic [7:0] code_of(input int top_code, input int idx);
    return 8'(top_code - 2 * idx);
  endfunction

endpackage

// File: rtl/ivc_pend_bank.sv
module ivc_pend_bank #(
  parameter int NUM_SRC = 60
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst) pend[g] <= 1'b0;
        else     pend[g] <= (pend[g] & ~clr[g]) | evt[g];
      end

      assert_pend_set_R7: assert property (@(posedge clk) disable iff (rst)
        evt[g] |=> pend[g]);

      assert_pend_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (clr[g] && !evt[g]) |=> !pend[g]);

      assert_pend_race_R9: assert property (@(posedge clk) disable iff (rst)
        (clr[g] && evt[g]) |=> pend[g]);

      assert_pend_retain_R10: assert property (@(posedge clk) disable iff (rst)
        (pend[g] && !clr[g]) |=> pend[g]);
    end
  endgenerate

endmodule

// File: rtl/ivc_pick.sv
module ivc_pick #(
  parameter int NUM_SRC = 60,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  // Lowest index wins: scan from the bottom of the priority order upward.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC  = 60,
  parameter int TOP_CODE = 8'h88
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               ack_wr,
  output logic [7:0]         vec_q,
  output logic               irq
);

  localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LOW_CODE = TOP_CODE - 2 * (NUM_SRC - 1);

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] cand;
  logic               cand_any;
  logic [IDX_W-1:0]   cand_idx;
  logic               cur_vld;
  logic [IDX_W-1:0]   cur_idx;
  logic               load;

  // Acknowledge mask: only the source the vector currently names.
  always_comb begin
    clr = '0;
    if (ack_wr && cur_vld) clr[cur_idx] = 1'b1;
  end

  ivc_pend_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .evt  (src_evt),
    .clr  (clr),
    .pend (pend)
  );

  assign cand = pend & src_en & ~clr;

  ivc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req (cand),
    .any (cand_any),
    .idx (cand_idx)
  );

  // Vector reloads on an acknowledge or while empty; otherwise it holds.
  assign load = ack_wr || !cur_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_vld <= 1'b0;
      cur_idx <= '0;
      vec_q   <= 8'h00;
      irq     <= 1'b0;
    end else begin
      if (load) begin
        cur_vld <= cand_any;
        cur_idx <= cand_idx;
        vec_q   <= cand_any ? code_of(TOP_CODE, int'(cand_idx)) : 8'h00;
      end
      irq <= |(pend & src_en);
    end
  end

  assert_vec_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (vec_q != 8'h00 && !ack_wr) |=> $stable(vec_q));

  assert_vec_code_R2: assert property (@(posedge clk) disable iff (rst)
    (vec_q != 8'h00) |-> (vec_q[0] == 1'b0 && int'(vec_q) <= TOP_CODE
                          && int'(vec_q) >= LOW_CODE));

  assert_pick_valid_R4: assert property (@(posedge clk) disable iff (rst)
    cand_any |-> cand[cand_idx]);

  assert_pick_empty_R3: assert property (@(posedge clk) disable iff (rst)
    !cand_any |-> (cand == '0));

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

  localparam int N   = 60;
  localparam int TOP = 8'h88;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src_evt = '0;
  logic [N-1:0] src_en  = '1;
  logic         ack_wr  = 1'b0;
  logic [7:0]   vec_q;
  logic         irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  irq_vector_ctrl #(.NUM_SRC(N), .TOP_CODE(TOP)) uut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .src_en(src_en),
    .ack_wr(ack_wr), .vec_q(vec_q), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] exp_code(input int i);
    return 8'(TOP - 2 * i);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic ack();
    ack_wr = 1'b1;
    @(negedge clk);
    ack_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 vec", vec_q, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h01 & 8'h00);
  endtask

  task automatic t_single();
    pulse(N'(1) << 5);
    check("R7 no vec before second edge", vec_q, 8'h00);
    cycles(1);
    check("R7 R2 vec src5", vec_q, exp_code(5));
    check("R8 irq set", {7'd0, irq}, 8'h01);
    ack();
    check("R5 R3 vec after ack", vec_q, 8'h00);
    cycles(1);
    check("R8 irq drop", {7'd0, irq}, 8'h00);
    ack();
    check("R5 ack on empty ignored", vec_q, 8'h00);
  endtask

  task automatic t_priority();
    pulse((N'(1) << 59) | (N'(1) << 3) | (N'(1) << 20));
    cycles(1);
    check("R4 first", vec_q, exp_code(3));
    ack();
    check("R4 second", vec_q, exp_code(20));
    ack();
    check("R2 lowest code", vec_q, 8'h12);
    ack();
    check("R3 empty", vec_q, 8'h00);
    cycles(1);
  endtask

  task automatic t_hold();
    pulse(N'(1) << 30);
    cycles(1);
    check("R6 initial", vec_q, exp_code(30));
    pulse(N'(1) << 1);
    cycles(3);
    check("R6 held against higher", vec_q, exp_code(30));
    ack();
    check("R6 R4 advance to higher", vec_q, 8'h86);
    ack();
    check("R3 empty after hold", vec_q, 8'h00);
    cycles(1);
  endtask

  task automatic t_mask();
    src_en[10] = 1'b0;
    pulse(N'(1) << 10);
    cycles(2);
    check("R10 masked vec", vec_q, 8'h00);
    check("R10 masked irq", {7'd0, irq}, 8'h00);
    src_en[10] = 1'b1;
    cycles(1);
    check("R10 enabled later", vec_q, exp_code(10));
    ack();
    check("R3 after masked", vec_q, 8'h00);
    cycles(1);
  endtask

  task automatic t_race();
    pulse(N'(1) << 7);
    cycles(1);
    check("R9 initial", vec_q, exp_code(7));
    src_evt = N'(1) << 7;
    ack_wr  = 1'b1;
    @(negedge clk);
    src_evt = '0;
    ack_wr  = 1'b0;
    check("R9 gap", vec_q, 8'h00);
    cycles(1);
    check("R9 re-presented", vec_q, exp_code(7));
    check("R9 irq held", {7'd0, irq}, 8'h01);
    ack();
    check("R9 final clear", vec_q, 8'h00);
    cycles(1);
  endtask

  task automatic t_top();
    pulse(N'(1));
    cycles(1);
    check("R2 highest code", vec_q, 8'h88);
    ack();
    check("R3 after top", vec_q, 8'h00);
  endtask

  initial begin
    cycles(3);
    rst = 1'b0;
    cycles(1);
    t_reset();
    t_single();
    t_priority();
    t_hold();
    t_mask();
    t_race();
    t_top();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule